// File: doc/BRIEF.md
# Carry-Chained Barrel Shifter

This block is a purely combinational shifter for a 32-bit processor datapath. It takes an operand, a 5-bit distance and an operation code. It returns the shifted word and a carry flag. Four shift kinds are provided: logical left, logical right, arithmetic right and rotate right. A fifth operation rotates the word right by one place through the incoming carry flag.

The shift is formed by a cascade of conditional stages. Each stage moves the word by a fixed power-of-two distance (16, 8, 4, 2, then 1). Each stage is switched on by the matching bit of the distance. A stage that fires works out the carry for its own move and hands it to the next stage. A stage that is idle forwards the carry it received without change. The carry flag at the bottom of the cascade is therefore the last bit that left the word, or the last bit that wrapped around. The datapath places this block between the register read and the ALU operand input.

Top module: `bsh_core`

## Requirements
- R1: Operation code 0 (logical left), distance n in 1..31: result equals operand shifted left by n with zeros entering bit 0; carry_out equals operand bit 32-n.
- R2: Operation code 1 (logical right), distance n in 1..31: result equals operand shifted right by n with zeros entering bit 31; carry_out equals operand bit n-1.
- R3: Operation code 2 (arithmetic right), distance n in 1..31: vacated upper bits take the operand's bit 31; carry_out equals operand bit n-1.
- R4: Operation code 3 (rotate right), distance n in 1..31: bits leaving bit 0 re-enter at bit 31; carry_out equals operand bit n-1, which is also result bit 31.
- R5: For operation codes 0 to 3 with distance 0, the result equals the operand and carry_out equals carry_in.
- R6: Operation code 4 (extended rotate): result bit 31 is carry_in, result bits 30..0 are operand bits 31..1, and carry_out is operand bit 0, whatever the distance.
- R7: carry_in has no effect on result or carry_out for operation codes 0 to 3 when the distance is nonzero.
- R8: Operation codes 5, 6 and 7 are reserved: the result equals the operand and carry_out equals carry_in, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opd_i | input | 32 | Operand word |
| amt_i | input | 5 | Shift distance |
| op_i | input | 3 | Operation code (0 left, 1 logical right, 2 arithmetic right, 3 rotate, 4 extended rotate, 5..7 reserved) |
| cin_i | input | 1 | Incoming carry flag |
| res_o | output | 32 | Shifted word |
| cout_o | output | 1 | Outgoing carry flag |

## Verification
The hardest case to reach is the carry produced by the last active stage of a long cascade. Distances such as 17, 24 or 31 switch on several stages, and the carry from a large stage must be overwritten by each smaller stage that fires after it. The stimulus therefore runs every distance from 0 to 31 for every operation code on operands with a single bit set, a single bit clear, and alternating patterns. With these operands a carry taken from the wrong stage gives a visibly different flag. Pseudo-random words are then added, with both values of the incoming carry, so that R7 is checked while the carry is toggled.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

   typedef enum logic [2:0] {
      OP_LSL  = 3'd0,
      OP_LSR  = 3'd1,
      OP_ASR  = 3'd2,
      OP_ROR  = 3'd3,
      OP_RRX  = 3'd4
   } bsh_op_e;

   typedef enum logic [1:0] {
      SK_LEFT  = 2'd0,
      SK_RIGHT = 2'd1,
      SK_ARITH = 2'd2,
      SK_ROT   = 2'd3
   } bsh_kind_e;

   function automatic bsh_kind_e kind_of(input logic [2:0] op);
      case (op)
         3'd1:    return SK_RIGHT;
         3'd2:    return SK_ARITH;
         3'd3:    return SK_ROT;
         default: return SK_LEFT;
      endcase
   endfunction

   function automatic logic is_reserved(input logic [2:0] op);
      return op > 3'd4;
   endfunction

endpackage

// File: rtl/bsh_stage.sv
module bsh_stage #(
   parameter int W = 32,
   parameter int D = 1
) (
   input  logic [W-1:0]        d_i,
   input  logic                c_i,
   input  logic                en_i,
   input  bsh_pkg::bsh_kind_e  kind_i,
   output logic [W-1:0]        d_o,
   output logic                c_o
);
   import bsh_pkg::*;

   if (D < 1 || D > W/2) begin : g_bad_dist
      $error("bsh_stage: distance %0d out of range for width %0d", D, W);
   end

   logic [W-1:0] left_w, right_w, arith_w, rot_w;

   assign left_w  = d_i << D;
   assign right_w = d_i >> D;
   assign arith_w = {{D{d_i[W-1]}}, d_i[W-1:D]};
   assign rot_w   = {d_i[D-1:0], d_i[W-1:D]};

   always_comb begin
      d_o = d_i;
      c_o = c_i;
      if (en_i) begin
         case (kind_i)
            SK_LEFT: begin
               d_o = left_w;
               c_o = d_i[W-D];
            end
            SK_RIGHT: begin
               d_o = right_w;
               c_o = d_i[D-1];
            end
            SK_ARITH: begin
               d_o = arith_w;
               c_o = d_i[D-1];
            end
            default: begin
               d_o = rot_w;
               c_o = d_i[D-1];
            end
         endcase
      end
   end

endmodule

// File: rtl/bsh_rrx.sv
module bsh_rrx #(
   parameter int W = 32
) (
   input  logic [W-1:0] d_i,
   input  logic         c_i,
   output logic [W-1:0] d_o,
   output logic         c_o
);
   assign d_o = {c_i, d_i[W-1:1]};
   assign c_o = d_i[0];
endmodule

// File: rtl/bsh_core.sv
module bsh_core #(
   parameter int W      = 32,
   parameter bit RRX_EN = 1'b1,
   localparam int AW    = $clog2(W)
) (
   input  logic [W-1:0]  opd_i,
   input  logic [AW-1:0] amt_i,
   input  logic [2:0]    op_i,
   input  logic          cin_i,
   output logic [W-1:0]  res_o,
   output logic          cout_o
);
   import bsh_pkg::*;

   localparam int NSTG = AW;

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("bsh_core: width %0d must be a power of two", W);
   end

   bsh_kind_e    kind_w;
   logic [W-1:0] dq [NSTG+1];
   logic         cq [NSTG+1];
   logic [W-1:0] rrx_d;
   logic         rrx_c;

   assign kind_w   = kind_of(op_i);
   assign dq[NSTG] = opd_i;
   assign cq[NSTG] = cin_i;

   for (genvar i = NSTG - 1; i >= 0; i--) begin : g_stage
      bsh_stage #(
         .W (W),
         .D (1 << i)
      ) stage_i (
         .d_i    (dq[i+1]),
         .c_i    (cq[i+1]),
         .en_i   (amt_i[i]),
         .kind_i (kind_w),
         .d_o    (dq[i]),
         .c_o    (cq[i])
      );
   end

   if (RRX_EN) begin : g_rrx
      bsh_rrx #(.W(W)) rrx_i (
         .d_i (opd_i),
         .c_i (cin_i),
         .d_o (rrx_d),
         .c_o (rrx_c)
      );
   end else begin : g_no_rrx
      assign rrx_d = opd_i;
      assign rrx_c = cin_i;
   end

   always_comb begin
      if (op_i == OP_RRX) begin
         res_o  = rrx_d;
         cout_o = rrx_c;
      end else if (is_reserved(op_i)) begin
         res_o  = opd_i;
         cout_o = cin_i;
      end else begin
         res_o  = dq[0];
         cout_o = cq[0];
      end
   end

endmodule

// File: rtl/bsh_core_chk.sv
module bsh_core_chk #(
   parameter int W  = 32,
   parameter int AW = 5
) (
   input logic [W-1:0]  opd_i,
   input logic [AW-1:0] amt_i,
   input logic [2:0]    op_i,
   input logic          cin_i,
   input logic [W-1:0]  res_o,
   input logic          cout_o
);
   always_comb begin
      if (op_i == 3'd0 && amt_i != '0)
         AST_LSL_ZERO_FILL: assert (res_o[0] == 1'b0); // R1
      if (op_i == 3'd1 && amt_i != '0)
         AST_LSR_ZERO_TOP: assert (res_o[W-1] == 1'b0); // R2
      if (op_i == 3'd2)
         AST_ASR_SIGN_KEPT: assert (res_o[W-1] == opd_i[W-1]); // R3
      if (op_i == 3'd3 && amt_i != '0)
         AST_ROR_CARRY_TOP: assert (cout_o == res_o[W-1]); // R4
      if (op_i < 3'd4 && amt_i == '0)
         AST_ZERO_DIST_PASS: assert (res_o == opd_i && cout_o == cin_i); // R5
      if (op_i == 3'd4)
         AST_RRX_CARRY_SWAP: assert (res_o[W-1] == cin_i && cout_o == opd_i[0]); // R6
      if (op_i > 3'd4)
         AST_RSVD_PASS: assert (res_o == opd_i && cout_o == cin_i); // R8
   end
endmodule

bind bsh_core bsh_core_chk #(.W(W), .AW(AW)) chk_i (
   .opd_i  (opd_i),
   .amt_i  (amt_i),
   .op_i   (op_i),
   .cin_i  (cin_i),
   .res_o  (res_o),
   .cout_o (cout_o)
);

// File: tb/bsh_core_tb_top.sv
module bsh_core_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] opd = '0;
   logic [4:0]  amt = '0;
   logic [2:0]  op  = '0;
   logic        cin = 1'b0;
   logic [31:0] res;
   logic        cout;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;

   bsh_core dut_i (
      .opd_i (opd), .amt_i (amt), .op_i (op), .cin_i (cin),
      .res_o (res), .cout_o (cout)
   );

   function automatic logic [32:0] model(input logic [2:0] o, input logic [31:0] a,
                                         input int n, input logic c);
      logic [31:0] r;
      logic        co;
      r = a; co = c;
      if (o == 3'd4) begin
         r = {c, a[31:1]}; co = a[0];
      end else if (o < 3'd4 && n != 0) begin
         for (int k = 0; k < 32; k++) begin
            int s;
            case (o)
               3'd0: r[k] = (k - n >= 0) ? a[k-n] : 1'b0;
               3'd1: r[k] = (k + n < 32) ? a[k+n] : 1'b0;
               3'd2: r[k] = (k + n < 32) ? a[k+n] : a[31];
               default: begin s = (k + n) % 32; r[k] = a[s]; end
            endcase
         end
         co = (o == 3'd0) ? a[32-n] : a[n-1];
      end
      return {co, r};
   endfunction

   function automatic string tag(input logic [2:0] o, input int n);
      if (o > 3'd4) return "R8";
      if (o == 3'd4) return "R6";
      if (n == 0) return "R5";
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         default: return "R4";
      endcase
   endfunction

   task automatic apply(input logic [2:0] o, input logic [31:0] a, input int n,
                        input logic c, input string t);
      logic [32:0] e;
      @(negedge clk);
      op = o; opd = a; amt = n[4:0]; cin = c;
      @(posedge clk); #1;
      e = model(o, a, n, c);
      n_chk++;
      if ({cout, res} !== e) begin
         n_fail++;
         $display("FAIL %s op=%0d amt=%0d opd=%h cin=%b: got res=%h cout=%b, expected res=%h cout=%b",
                  t, o, n, a, c, res, cout, e[31:0], e[32]);
      end
   endtask

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang, expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] lfsr;
      logic [31:0] pats [6];
      pats[0] = 32'h0000_0001; pats[1] = 32'h8000_0000; pats[2] = 32'hFFFF_FFFE;
      pats[3] = 32'h7FFF_FFFF; pats[4] = 32'hAAAA_5555; pats[5] = 32'h1234_5678;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all-zero inputs give zero result and zero carry (R5)
      apply(3'd0, 32'h0, 0, 1'b0, "R5");
      // R5 with carry set at distance zero
      apply(3'd3, 32'hDEAD_BEEF, 0, 1'b1, "R5");
      // R6 distance ignored, both carry values
      apply(3'd4, 32'h0000_0001, 17, 1'b0, "R6");
      apply(3'd4, 32'h8000_0000, 0, 1'b1, "R6");
      // R8 reserved codes
      for (int o = 5; o < 8; o++) apply(o[2:0], 32'hCAFE_F00D, 13, 1'b1, "R8");
      // R1..R5 full distance sweep per op and pattern, both carries (R7)
      for (int o = 0; o < 5; o++)
         for (int p = 0; p < 6; p++)
            for (int n = 0; n < 32; n++)
               for (int c = 0; c < 2; c++)
                  apply(o[2:0], pats[p], n, c[0], tag(o[2:0], n));
      // R7: carry_in toggled on random operands and distances
      lfsr = 32'hACE1_2468;
      for (int i = 0; i < 3000; i++) begin
         logic [2:0] o;
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         o = lfsr[2:0];
         apply(o, lfsr, int'(lfsr[9:5]), lfsr[12],
               (o < 3'd4 && lfsr[9:5] != 0) ? "R7" : tag(o, int'(lfsr[9:5])));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule